// File: doc/BRIEF.md
# Floating-Point Exception Trap Decision Unit

This block sits behind a floating-point execution stage. Each time an instruction retires, the block takes the exception flags that the instruction raised. It decides which flags are recorded in a sticky exception field and whether the instruction traps. When a trap fires, it produces a summary word that lists the trapping causes, and a one-hot mask that names the destination register.

The block has two decision paths, chosen by a mode bit that travels with each instruction.
- **Plain path.** Every raised flag is recorded. Any flag that the per-instruction ignore mask does not suppress causes a trap. The enable mask plays no part.
- **Software-completion path.** The ignore mask is removed first, and only the flags that remain are recorded. The trap summary carries the remaining flags gated by the enable mask, together with a completion tag. A trap still fires when the gate leaves nothing.

The sticky field holds its value until reset or until a clear strobe arrives. The trap pulse, the summary and the register mask are registered and appear one cycle after the instruction is presented.

Top module: `fpx_trap_unit`

## Requirements
- R1: While reset is held, and after it is released, sticky_o, trap_o, summary_o and reg_mask_o are all zero.
- R2: Flag bit positions are fixed: bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact, bit5 integer overflow. In plain mode (swc_mode_i=0), a valid instruction ORs all of flags_i into sticky_o on the clock edge that samples valid_i, including flags that ignore_i suppresses.
- R3: In plain mode, trap_o is high in the cycle after a valid instruction exactly when flags_i & ~ignore_i is nonzero. enable_i has no effect on the outcome.
- R4: Flag bit k maps to summary_o bit k+1, and summary_o bit0 is the completion tag. In plain mode, a trap's summary holds flags_i & ~ignore_i with bit0 clear. summary_o is zero whenever trap_o is low.
- R5: In software-completion mode (swc_mode_i=1), only flags_i & ~ignore_i is ORed into sticky_o. Ignored flags are not recorded.
- R6: In software-completion mode, a trap fires when flags_i & ~ignore_i is nonzero. Its summary holds (flags_i & ~ignore_i & enable_i) with bit0 set, so it holds only bit0 when no remaining flag is enabled.
- R7: During a trap, reg_mask_o is one-hot with only bit dest_reg_i set. Otherwise it is zero.
- R8: When valid_i is low, or the flags left to record are zero, sticky_o does not change and trap_o stays low. A trap lasts one cycle for each trapping instruction.
- R9: clr_i clears sticky_o on the next edge. If a valid instruction arrives in the same cycle, sticky_o then holds only that instruction's recorded flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction result strobe |
| flags_i | input | 6 | Raised exception flags |
| ignore_i | input | 6 | Per-instruction ignore mask |
| swc_mode_i | input | 1 | Software-completion mode |
| dest_reg_i | input | 6 | Destination register number |
| enable_i | input | 6 | Trap enable mask (software-completion only) |
| clr_i | input | 1 | Write strobe that clears the sticky field |
| sticky_o | output | 6 | Sticky exception field |
| trap_o | output | 1 | One-cycle trap pulse |
| summary_o | output | 7 | Exception summary: bit0 completion tag, bits 6:1 causes |
| reg_mask_o | output | 64 | One-hot destination register mask |

## Verification
A wrong sticky state shows on sticky_o one edge after the instruction that corrupted it, so the per-cycle comparison catches it right away. That includes a lost bit, a bit recorded despite being ignored, or a bit that survives a clear.

A wrong mode decision shows on trap_o, summary_o and reg_mask_o in the cycle after the strobe:
- a trap that fires or is missing;
- a completion tag set in the wrong mode;
- enable gating applied in the wrong mode.

The one-hot decoder is swept across low, middle and top register numbers, so that an addressing fault cannot hide.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FPX_FLAGS = 6;

  typedef enum int {
    FLG_INV = 0,
    FLG_DZE = 1,
    FLG_OVF = 2,
    FLG_UNF = 3,
    FLG_INE = 4,
    FLG_IOV = 5
  } flag_idx_e;

  localparam int SUM_TAG_BIT = 0;
endpackage

// File: rtl/fpx_filter.sv
module fpx_filter #(
  parameter int NUM_FLAGS = fpx_pkg::FPX_FLAGS,
  localparam int SUM_W = NUM_FLAGS + 1
) (
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] ignore_i,
  input  logic [NUM_FLAGS-1:0] enable_i,
  input  logic                 swc_mode_i,
  output logic [NUM_FLAGS-1:0] record_o,
  output logic                 fire_o,
  output logic [SUM_W-1:0]     summary_o
);
  logic [NUM_FLAGS-1:0] kept;
  logic [NUM_FLAGS-1:0] causes;

  always_comb begin
    kept   = flags_i & ~ignore_i;
    fire_o = |kept;
    if (swc_mode_i) begin
      record_o = kept;
      causes   = kept & enable_i;
    end else begin
      // plain path records everything and traps on everything unignored
      record_o = flags_i;
      causes   = kept;
    end
    summary_o = {causes, swc_mode_i};
  end
endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky #(
  parameter int NUM_FLAGS = fpx_pkg::FPX_FLAGS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 valid_i,
  input  logic [NUM_FLAGS-1:0] record_i,
  output logic [NUM_FLAGS-1:0] sticky_o
);
  logic [NUM_FLAGS-1:0] base;
  logic [NUM_FLAGS-1:0] add;

  always_comb begin
    base = clr_i ? '0 : sticky_o;
    add  = valid_i ? record_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_o <= '0;
    else         sticky_o <= base | add;
  end

  assert_sticky_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)))
    else $error("sticky lost a bit");

  assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !valid_i) |=> $stable(sticky_o))
    else $error("sticky changed without valid");

  assert_sticky_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !valid_i) |=> (sticky_o == '0))
    else $error("sticky not cleared");
endmodule

// File: rtl/fpx_onehot.sv
module fpx_onehot #(
  parameter int ADDR_W = 6,
  localparam int NUM_OUT = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_OUT-1:0] onehot_o
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_dec
    assign onehot_o[g] = (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/fpx_trap_unit.sv
module fpx_trap_unit #(
  parameter int NUM_FLAGS  = fpx_pkg::FPX_FLAGS,
  parameter int REG_ADDR_W = 6,
  localparam int SUM_W    = NUM_FLAGS + 1,
  localparam int NUM_REGS = 1 << REG_ADDR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [NUM_FLAGS-1:0]  flags_i,
  input  logic [NUM_FLAGS-1:0]  ignore_i,
  input  logic                  swc_mode_i,
  input  logic [REG_ADDR_W-1:0] dest_reg_i,
  input  logic [NUM_FLAGS-1:0]  enable_i,
  input  logic                  clr_i,
  output logic [NUM_FLAGS-1:0]  sticky_o,
  output logic                  trap_o,
  output logic [SUM_W-1:0]      summary_o,
  output logic [NUM_REGS-1:0]   reg_mask_o
);
  logic [NUM_FLAGS-1:0] record;
  logic                 fire;
  logic [SUM_W-1:0]     summary_d;
  logic [NUM_REGS-1:0]  dest_oh;
  logic                 take;

  fpx_filter #(.NUM_FLAGS(NUM_FLAGS)) u_filter (
    .flags_i    (flags_i),
    .ignore_i   (ignore_i),
    .enable_i   (enable_i),
    .swc_mode_i (swc_mode_i),
    .record_o   (record),
    .fire_o     (fire),
    .summary_o  (summary_d)
  );

  fpx_sticky #(.NUM_FLAGS(NUM_FLAGS)) u_sticky (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .valid_i  (valid_i),
    .record_i (record),
    .sticky_o (sticky_o)
  );

  fpx_onehot #(.ADDR_W(REG_ADDR_W)) u_dec (
    .addr_i   (dest_reg_i),
    .onehot_o (dest_oh)
  );

  assign take = valid_i & fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o     <= 1'b0;
      summary_o  <= '0;
      reg_mask_o <= '0;
    end else begin
      trap_o     <= take;
      summary_o  <= take ? summary_d : '0;
      reg_mask_o <= take ? dest_oh : '0;
    end
  end

  assert_trap_needs_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(valid_i))
    else $error("trap without valid");

  assert_summary_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (summary_o == '0))
    else $error("summary nonzero without trap");

  assert_tag_follows_mode_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (summary_o[fpx_pkg::SUM_TAG_BIT] == $past(swc_mode_i)))
    else $error("completion tag mismatch");

  assert_mask_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ($countones(reg_mask_o) == 1))
    else $error("register mask not one-hot");

  assert_mask_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> (reg_mask_o == '0))
    else $error("register mask set without trap");

  assert_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !$past(valid_i, 1)) |-> 1'b0)
    else $error("trap not tied to an instruction");
endmodule

// File: tb/fpx_trap_unit_test.sv
module fpx_trap_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  flags_i = '0;
  logic [5:0]  ignore_i = '0;
  logic        swc_mode_i = 1'b0;
  logic [5:0]  dest_reg_i = '0;
  logic [5:0]  enable_i = '0;
  logic        clr_i = 1'b0;
  logic [5:0]  sticky_o;
  logic        trap_o;
  logic [6:0]  summary_o;
  logic [63:0] reg_mask_o;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  // reference model state
  logic [5:0]  m_sticky = '0;
  logic        m_trap = 1'b0;
  logic [6:0]  m_sum = '0;
  logic [63:0] m_mask = '0;

  always #10 clk_i = ~clk_i;

  fpx_trap_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .flags_i(flags_i),
    .ignore_i(ignore_i), .swc_mode_i(swc_mode_i), .dest_reg_i(dest_reg_i),
    .enable_i(enable_i), .clr_i(clr_i), .sticky_o(sticky_o), .trap_o(trap_o),
    .summary_o(summary_o), .reg_mask_o(reg_mask_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sticky <= '0; m_trap <= 1'b0; m_sum <= '0; m_mask <= '0;
    end else begin
      logic [5:0] rem;
      logic [5:0] rec;
      logic [5:0] ns;
      rem = '0;
      rec = '0;
      for (int i = 0; i < 6; i++) begin
        if (flags_i[i] && !ignore_i[i]) rem[i] = 1'b1;
        if (valid_i && flags_i[i] && (!swc_mode_i || !ignore_i[i])) rec[i] = 1'b1;
      end
      ns = clr_i ? 6'd0 : m_sticky;
      m_sticky <= ns | rec;
      if (valid_i && rem != 0) begin
        logic [6:0] s;
        s = '0;
        s[0] = swc_mode_i;
        for (int i = 0; i < 6; i++)
          s[i+1] = rem[i] && (!swc_mode_i || enable_i[i]);
        m_trap <= 1'b1;
        m_sum  <= s;
        m_mask <= 64'd1 << dest_reg_i;
      end else begin
        m_trap <= 1'b0; m_sum <= '0; m_mask <= '0;
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // compare on every falling edge, inputs are changed right after
  always @(negedge clk_i) begin
    chk("sticky", 64'(sticky_o), 64'(m_sticky));
    chk("trap", 64'(trap_o), 64'(m_trap));
    chk("summary", 64'(summary_o), 64'(m_sum));
    chk("regmask", reg_mask_o, m_mask);
  end

  task automatic op(bit v, bit swc, logic [5:0] f, logic [5:0] ig,
                    logic [5:0] en, logic [5:0] d, bit clr);
    @(negedge clk_i);
    #1;
    valid_i = v; swc_mode_i = swc; flags_i = f; ignore_i = ig;
    enable_i = en; dest_reg_i = d; clr_i = clr;
  endtask

  task automatic idle();
    op(0, 0, 6'h3f, 6'h00, 6'h3f, 6'd7, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    tag = "R1";
    chk("reset sticky", 64'(sticky_o), 0);
    chk("reset trap", 64'(trap_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    tag = "R2";  // plain, ignored flags still recorded
    op(1, 0, 6'b010101, 6'b000101, 6'h00, 6'd3, 0);
    idle();
    tag = "R3";  // plain, everything ignored, enable irrelevant
    op(1, 0, 6'b100010, 6'b100010, 6'h00, 6'd9, 0);
    op(1, 0, 6'b001000, 6'b000000, 6'h00, 6'd9, 0);
    tag = "R4";
    op(1, 0, 6'b111111, 6'b000000, 6'h15, 6'd0, 0);
    tag = "R9";  // clear alone, then clear with valid
    op(0, 0, 6'h00, 6'h00, 6'h00, 6'd0, 1);
    op(1, 0, 6'b000001, 6'h00, 6'h00, 6'd1, 0);
    op(1, 1, 6'b000110, 6'h00, 6'h3f, 6'd2, 1);
    idle();
    op(0, 0, 6'h00, 6'h00, 6'h00, 6'd0, 1);
    tag = "R5";  // swc, ignored flags not recorded
    op(1, 1, 6'b110011, 6'b010001, 6'h3f, 6'd12, 0);
    idle();
    tag = "R6";  // swc, partial enables, then empty enables
    op(1, 1, 6'b001110, 6'b000000, 6'b000100, 6'd40, 0);
    op(1, 1, 6'b001110, 6'b000000, 6'b000000, 6'd41, 0);
    op(1, 1, 6'b010000, 6'b010000, 6'h3f, 6'd42, 0);
    tag = "R7";
    op(1, 0, 6'd1, 6'd0, 6'd0, 6'd0, 0);
    op(1, 0, 6'd1, 6'd0, 6'd0, 6'd1, 0);
    op(1, 0, 6'd1, 6'd0, 6'd0, 6'd31, 0);
    op(1, 0, 6'd1, 6'd0, 6'd0, 6'd63, 0);
    tag = "R8";  // back-to-back then idle, zero flags
    idle();
    op(1, 0, 6'd0, 6'd0, 6'h3f, 6'd5, 0);
    op(1, 1, 6'd0, 6'd0, 6'h3f, 6'd5, 0);
    idle();
    tag = "R3";  // random mix
    for (int n = 0; n < 400; n++) begin
      op(1'($urandom), 1'($urandom), 6'($urandom), 6'($urandom),
         6'($urandom), 6'($urandom), ($urandom % 16) == 0);
    end
    idle();
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule